// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Sequence

A memory-mapped watchdog that must be serviced by software at regular intervals. A down counter, clocked through a fixed divide-by-four prescaler, counts toward zero from a programmable reload value. If software fails to service it in time, the block asks the system to reset. Software services the watchdog by writing a two-byte key to the feed location. The same key sequence is also what brings the counter to life after the watchdog has been enabled.

The control bits can only be set by software. Only the block's own reset input clears them, so a runaway program cannot switch the watchdog off once it is armed. A malformed or interrupted key sequence is treated as a fault. When the watchdog is enabled and resets are permitted, such a fault produces an immediate reset request, without waiting for the counter to expire.

The register bus has one access per cycle, with separate write and read strobes, a 4-bit byte address and 32-bit data. Writes are sampled on the rising clock edge. Read data is combinational from the address.

Top module: `wdog_feed`

## Requirements
- R1: While the watchdog is running, the count value drops by exactly one every 4 clock cycles.
- R2: Register locations: 0x0 holds the control register, 0x4 the reload value, 0x8 the feed key and 0xC the count. In the control register, bit 0 is enable, bit 1 is reset-permit and bit 2 is the timeout flag. The feed location reads as zero. Writes to 0xC change nothing.
- R3: A reload value written below 0xFF is stored as 0xFF. Bits 31:24 of the write data are ignored.
- R4: A feed is a write of 0xAA to 0x8 whose next bus access is a write of 0x55 to 0x8. A feed loads the count from the reload value. Idle cycles between the two writes are allowed.
- R5: Setting enable alone does not start counting. The count stays still and no reset is requested until a feed completes while enable is set.
- R6: Enable and reset-permit are set-only from the bus. Writing 0 leaves them set. The block reset clears them.
- R7: When a running count at 0 receives a tick, the timeout flag is set and the count reloads. If reset-permit is set, the reset request goes high for exactly 4 cycles, starting in the cycle after that edge.
- R8: If the write that follows 0xAA to 0x8 carries any byte other than 0x55, the feed fails. With enable and reset-permit both set, the reset request rises in the next cycle.
- R9: Any other read or write between the two key writes aborts the feed, and the count is not reloaded. With enable and reset-permit set, the abort raises the reset request as in R8.
- R10: After reset: control register 0, reload value 0xFF, count 0xFF, reset request low.
- R11: With reset-permit clear, an underflow sets the timeout flag but never raises the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (counts as an access for the feed sequence) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit counter, a divide-by-four prescaler and a 4-cycle request pulse. It lowers the reload value to its 0xFF floor, so that an underflow arrives after about a thousand cycles. Both the quiet timeout (permit clear) and the reset-raising timeout can therefore be reached in the same run, alongside the keyed-sequence faults.

// File: rtl/wdog_feed.sv
module wdog_feed #(
  parameter int CNT_W     = 24,
  parameter int DIV       = 4,
  parameter int PULSE_LEN = 4,
  parameter logic [CNT_W-1:0] TC_MIN = 'hFF,
  parameter logic [7:0] KEY1 = 8'hAA,
  parameter logic [7:0] KEY2 = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sys_rst_req
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PUL_W = $clog2(PULSE_LEN + 1);
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_TC   = 4'h4;
  localparam logic [3:0] A_FEED = 4'h8;
  localparam logic [3:0] A_CNT  = 4'hC;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic             en, rst_en, tflag, running, pend;
  logic [CNT_W-1:0] tc, cnt;
  logic [PRE_W-1:0] pre;
  logic [PUL_W-1:0] pulse;

  logic access, wr_feed, key2_ok, feed_bad, tick, uf, fire;
  logic [CNT_W-1:0] wval;

  assign access   = bus_wr | bus_rd;
  assign wr_feed  = bus_wr && bus_addr == A_FEED;
  assign key2_ok  = pend && wr_feed && bus_wdata[7:0] == KEY2;
  assign feed_bad = pend && access && !key2_ok;
  assign tick     = running && pre == PRE_LAST;
  assign uf       = tick && cnt == '0;
  assign fire     = (uf && rst_en) || (feed_bad && en && rst_en);
  assign wval     = bus_wdata[CNT_W-1:0];
  assign sys_rst_req = pulse != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; rst_en <= 1'b0; tflag <= 1'b0; running <= 1'b0;
      pend <= 1'b0; tc <= TC_MIN;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) begin
        en     <= en | bus_wdata[0];
        rst_en <= rst_en | bus_wdata[1];
      end
      if (bus_wr && bus_addr == A_TC)
        tc <= (wval < TC_MIN) ? TC_MIN : wval;
      if (access)
        pend <= !pend && wr_feed && bus_wdata[7:0] == KEY1;
      if (key2_ok && en)
        running <= 1'b1;
      if (uf)
        tflag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= TC_MIN; pre <= '0;
    end else if (key2_ok) begin
      cnt <= tc; pre <= '0;
    end else if (running) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= uf ? tc : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pulse <= '0;
    else if (fire)     pulse <= PUL_W'(PULSE_LEN);
    else if (pulse != '0) pulse <= pulse - 1'b1;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {29'd0, tflag, rst_en, en};
      A_TC:    bus_rdata = 32'(tc);
      A_CNT:   bus_rdata = 32'(cnt);
      default: bus_rdata = '0;
    endcase
  end

  // R6
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> en);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !key2_ok) |=> $stable(cnt));
  // R5
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) running |-> en);
  // R1
  prescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pre != PRE_LAST && !key2_ok) |=> $stable(cnt));
  // R11
  req_permit_chk: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_req |-> rst_en);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) tflag |=> tflag);
  // R3
  tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) tc >= TC_MIN);
endmodule

// File: tb/sim_wdog_feed.sv
module sim_wdog_feed;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sys_rst_req;

  wdog_feed u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                .sys_rst_req(sys_rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  string phase = "R10";

  // behavioural reference
  int m_en, m_pe, m_fl, m_run, m_pend, m_tc, m_cnt, m_ticks, m_pulse;
  task automatic m_reset();
    m_en = 0; m_pe = 0; m_fl = 0; m_run = 0; m_pend = 0;
    m_tc = 255; m_cnt = 255; m_ticks = 0; m_pulse = 0;
  endtask
  initial m_reset();

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_reset();
    else begin
      bit acc, good, bad, trig;
      acc = bus_wr || bus_rd; good = 0; bad = 0; trig = 0;
      if (m_pend != 0) begin
        if (acc) begin
          if (bus_wr && bus_addr == 8 && bus_wdata[7:0] == 8'h55) good = 1; else bad = 1;
          m_pend = 0;
        end
      end else if (bus_wr && bus_addr == 8 && bus_wdata[7:0] == 8'hAA) m_pend = 1;
      if (good) begin
        m_cnt = m_tc; m_ticks = 0;
        if (m_en != 0) m_run = 1;
      end else if (m_run != 0) begin
        m_ticks++;
        if (m_ticks == 4) begin
          m_ticks = 0;
          if (m_cnt == 0) begin
            m_cnt = m_tc; m_fl = 1;
            if (m_pe != 0) trig = 1;
          end else m_cnt--;
        end
      end
      if (bad && m_en != 0 && m_pe != 0) trig = 1;
      if (trig) m_pulse = 4; else if (m_pulse > 0) m_pulse--;
      if (bus_wr && bus_addr == 0) begin
        if (bus_wdata[0]) m_en = 1;
        if (bus_wdata[1]) m_pe = 1;
      end
      if (bus_wr && bus_addr == 4)
        m_tc = (int'(bus_wdata[23:0]) < 255) ? 255 : int'(bus_wdata[23:0]);
    end
  end

  function automatic int m_rdata(input logic [3:0] a);
    case (a)
      4'h0: return m_fl * 4 + m_pe * 2 + m_en;
      4'h4: return m_tc;
      4'hC: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=0x%0h expected=0x%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({phase, " rdata"}, int'(bus_rdata), m_rdata(bus_addr));
    check({phase, " req"}, int'(sys_rst_req), (m_pulse != 0) ? 1 : 0);
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a);
    @(posedge clk); #1 bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask
  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
  endtask
  task automatic wait_req(input string tag);
    int n = 0;
    while (!sys_rst_req && n < 3000) begin @(negedge clk); n++; end
    check({tag, " request seen"}, int'(sys_rst_req), 1);
    n = 0;
    while (sys_rst_req && n < 20) begin @(negedge clk); n++; end
    check({tag, " pulse width"}, n, 4);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; @(negedge clk);
    phase = "R10";
    bus_addr = 4'h0; #1 check("R10 ctrl", int'(bus_rdata), 0);
    bus_addr = 4'h4; #1 check("R10 reload", int'(bus_rdata), 255);
    bus_addr = 4'hC; #1 check("R10 count", int'(bus_rdata), 255);
    check("R10 req", int'(sys_rst_req), 0);

    phase = "R3";
    wr(4'h4, 32'h10); bus_addr = 4'h4; #1 check("R3 clamp", int'(bus_rdata), 255);
    wr(4'h4, 32'h7F00_0120); #1 check("R3 upper ignored", int'(bus_rdata), 32'h120);
    wr(4'h4, 32'h100);

    phase = "R2";
    wr(4'hC, 32'h1234); rd(4'hC); check("R2 count read-only", int'(bus_rdata), 255);
    rd(4'h8); check("R2 feed reads zero", int'(bus_rdata), 0);

    phase = "R4";
    wr(4'h8, 32'hAA); idle(2); wr(4'h8, 32'h55); rd(4'hC);
    check("R4 reload", int'(bus_rdata), 32'h100);
    phase = "R5"; idle(40); check("R5 not running", int'(bus_rdata), 32'h100);
    wr(4'h0, 32'h1); bus_addr = 4'hC; idle(40);
    check("R5 enable alone", int'(bus_rdata), 32'h100);

    phase = "R6";
    wr(4'h0, 32'h0); rd(4'h0); check("R6 enable kept", int'(bus_rdata), 1);

    phase = "R9";
    wr(4'h4, 32'h150); wr(4'h8, 32'hAA); rd(4'h0); wr(4'h8, 32'h55); rd(4'hC);
    check("R9 abort no reload", int'(bus_rdata), 32'h100);

    phase = "R1";
    wr(4'h4, 32'h0); wr(4'h8, 32'hAA); wr(4'h8, 32'h55); bus_addr = 4'hC;
    idle(41); check("R1 ten ticks", int'(bus_rdata), 255 - 10);

    phase = "R11";
    idle(1100); bus_addr = 4'h0; #1;
    check("R11 flag set", int'(bus_rdata[2]), 1);

    phase = "R7";
    wr(4'h0, 32'h2); wr(4'h8, 32'hAA); wr(4'h8, 32'h55); bus_addr = 4'hC;
    wait_req("R7");

    phase = "R8";
    wr(4'h8, 32'hAA); wr(4'h8, 32'h12); @(negedge clk);
    check("R8 immediate", int'(sys_rst_req), 1);
    idle(6);

    phase = "R9";
    wr(4'h8, 32'hAA); wr(4'h4, 32'h200); @(negedge clk);
    check("R9 abort request", int'(sys_rst_req), 1);
    idle(6);

    phase = "R6";
    do_reset(); bus_addr = 4'h0; @(negedge clk);
    check("R6 cleared by reset", int'(bus_rdata), 0);
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule